// File: doc/BRIEF.md
# Local and Remote Wake-Up Detector

This block watches for wake-up requests while a bus transceiver sits in one of its low-power modes. There are two sources. A local wake input must move to a new logic level and stay there for a configurable number of clock cycles. A bus-dominant indication from the low-power receiver must stay asserted for its own configurable number of cycles. Each source has its own stability filter. A pulse that is too short leaves no trace, and the count starts again from zero.

An accepted request raises a wake flag and sends a single-cycle event to the mode controller. A request is accepted only in the three low-power modes, and only outside the undervoltage waiting period. A local request also raises a source flag, provided the power-on flag is clear. The wake flag clears on entry to normal mode and when the supply undervoltage flag is newly set. The source flag stays set through normal mode and clears when normal mode is left. All inputs are taken to be synchronous to `clk`. The reset is asynchronous and is released through a two-stage synchronizer inside the block.

Top module: `wkup_detect`

## Requirements
- R1: While reset is active, and directly after it, `wake_flag_o`, `wake_src_o` and `wake_evt_o` are 0.
- R2: A local request occurs when `wake_pin_i` differs from its last stable level at T_WAKE consecutive rising edges. This holds for both rising and falling changes. The wake flag then rises at the T_WAKE-th of those edges, and the new level becomes the stable level.
- R3: If `wake_pin_i` returns to its stable level before T_WAKE edges have passed, no request occurs. A later change counts again from zero.
- R4: A remote request occurs when `bus_dom_i` is 1 at T_BUS consecutive edges. The flag rises at the T_BUS-th edge. One dominant run yields at most one request, so the bus must go recessive before another request can occur.
- R5: A request sets the flag only when `mode_i` is 2 (standby), 3 (go-to-sleep command) or 4 (sleep). Codes 0 (normal), 1 (listen-only) and 5 to 7 never set it.
- R6: While `uvnom_wait_i` is 1, requests are ignored.
- R7: The wake flag clears at an edge where `mode_i` is 0, or where `uvnom_i` is 1 after being 0 at the previous edge. Either clear takes priority over a request at the same edge. A `uvnom_i` that stays high does not block requests.
- R8: An accepted local request also sets `wake_src_o`, provided `pwon_i` is 0 and the wake flag is not being cleared at that edge. A remote request, or a local request while `pwon_i` is 1, leaves it unchanged.
- R9: `wake_src_o` holds its value while `mode_i` stays 0. It clears at the first edge where `mode_i` is non-zero after being 0 at the previous edge, unless R8 sets it at that same edge.
- R10: `wake_evt_o` is high for exactly the one cycle in which the wake flag first shows 1. Further requests while the flag is already set give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_pin_i | input | 1 | Local wake input level |
| bus_dom_i | input | 1 | 1 when the low-power receiver sees the bus dominant |
| mode_i | input | 3 | Current operating mode code (0 normal, 1 listen-only, 2 standby, 3 go-to-sleep, 4 sleep) |
| pwon_i | input | 1 | Power-on flag |
| uvnom_i | input | 1 | Supply undervoltage flag |
| uvnom_wait_i | input | 1 | Undervoltage waiting period active |
| wake_flag_o | output | 1 | Wake-up flag |
| wake_src_o | output | 1 | Wake-up came from the local input |
| wake_evt_o | output | 1 | One-cycle wake event to the mode controller |

## Verification
Each flag appears after the T_WAKE-th or T_BUS-th rising edge at which the new input level is sampled. A mode or undervoltage clear takes effect at the first edge that samples it, and the event pulse appears in the same cycle as the flag. The bench changes inputs on falling edges and reads outputs on falling edges. It counts the exact number of edges before each read, so every check falls just after the edge that should have produced the result. Filter lengths are swept from well below the threshold to above it for both pin polarities and for the bus, and every mode code is tried. Event pulses are counted over each window rather than probed once.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL  = 3'd0,
    MODE_LISTEN  = 3'd1,
    MODE_STANDBY = 3'd2,
    MODE_GOSLEEP = 3'd3,
    MODE_SLEEP   = 3'd4
  } tcv_mode_e;

  // Wake requests are honoured only in the three power-saving modes.
  function automatic logic is_low_power(input logic [MODE_W-1:0] m);
    return (m == MODE_STANDBY) || (m == MODE_GOSLEEP) || (m == MODE_SLEEP);
  endfunction

endpackage

// File: rtl/wkup_level_filter.sv
// Reports a level change on a pin once it has held for T_STABLE samples.
module wkup_level_filter #(
  parameter int T_STABLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic hit_o
);
  localparam int CW = $clog2(T_STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(T_STABLE - 1);

  logic          primed_q, primed_d;
  logic          ref_q, ref_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differ;

  assign differ = primed_q && (pin_i != ref_q);
  assign hit_o  = differ && (cnt_q == LAST);

  always_comb begin
    primed_d = primed_q;
    ref_d    = ref_q;
    cnt_d    = cnt_q;
    if (!primed_q) begin
      primed_d = 1'b1;
      ref_d    = pin_i;
      cnt_d    = '0;
    end else if (hit_o) begin
      ref_d = pin_i;
      cnt_d = '0;
    end else if (differ) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      ref_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      primed_q <= primed_d;
      ref_q    <= ref_d;
      cnt_q    <= cnt_d;
    end
  end

  generate
    if (T_STABLE >= 2) begin : g_chk
      // R3: a request needs the pin unchanged across the last sample.
      p_stable_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $stable(pin_i));
    end
  endgenerate

endmodule

// File: rtl/wkup_dom_filter.sv
// Reports one request per dominant run lasting T_DOM samples.
module wkup_dom_filter #(
  parameter int T_DOM = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dom_i,
  output logic hit_o
);
  localparam int CW = $clog2(T_DOM + 1);
  localparam logic [CW-1:0] LAST = CW'(T_DOM - 1);
  localparam logic [CW-1:0] SAT  = CW'(T_DOM);

  logic [CW-1:0] cnt_q, cnt_d;

  assign hit_o = dom_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!dom_i) begin
      cnt_d = '0;
    end else if (cnt_q != SAT) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4: never two requests on consecutive edges.
  p_single_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);

endmodule

// File: rtl/wkup_flag_ctl.sv
// Gates requests by mode and waiting period, keeps the wake and source flags.
module wkup_flag_ctl
  import wkup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              local_hit_i,
  input  logic              bus_hit_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              pwon_i,
  input  logic              uvnom_i,
  input  logic              uvnom_wait_i,
  output logic              wake_flag_o,
  output logic              wake_src_o,
  output logic              wake_evt_o
);
  logic              flag_q, flag_d;
  logic              src_q, src_d;
  logic              evt_q, evt_d;
  logic              uv_q;
  logic [MODE_W-1:0] mode_q;

  logic accept, uv_rise, flag_clr, src_set, left_normal;

  always_comb begin
    accept      = is_low_power(mode_i) && !uvnom_wait_i && (local_hit_i || bus_hit_i);
    uv_rise     = uvnom_i && !uv_q;
    flag_clr    = (mode_i == MODE_NORMAL) || uv_rise;
    src_set     = accept && !flag_clr && local_hit_i && !pwon_i;
    left_normal = (mode_q == MODE_NORMAL) && (mode_i != MODE_NORMAL);

    flag_d = flag_q;
    if (flag_clr)    flag_d = 1'b0;
    else if (accept) flag_d = 1'b1;

    evt_d = !flag_clr && accept && !flag_q;

    src_d = src_q;
    if (src_set)          src_d = 1'b1;
    else if (left_normal) src_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      src_q  <= 1'b0;
      evt_q  <= 1'b0;
      uv_q   <= 1'b0;
      mode_q <= MODE_NORMAL;
    end else begin
      flag_q <= flag_d;
      src_q  <= src_d;
      evt_q  <= evt_d;
      uv_q   <= uvnom_i;
      mode_q <= mode_i;
    end
  end

  assign wake_flag_o = flag_q;
  assign wake_src_o  = src_q;
  assign wake_evt_o  = evt_q;

  // R5: the flag only rises after an edge sampled in a low-power mode.
  p_rise_in_lp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag_o) |-> is_low_power($past(mode_i)));

  // R6: the flag never rises from an edge inside the waiting period.
  p_wait_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag_o) |-> !$past(uvnom_wait_i));

  // R7: normal mode empties the flag on the next edge.
  p_normal_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_NORMAL) |=> !wake_flag_o);

  // R8: the source flag never rises from an edge with power-on set.
  p_src_pwon_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_src_o) |-> !$past(pwon_i));

  // R9: staying in normal mode keeps the source flag.
  p_src_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_NORMAL) && ($past(mode_i) == MODE_NORMAL)) |=> $stable(wake_src_o));

  // R10: the event accompanies the first cycle of a set flag.
  p_evt_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt_o |-> (wake_flag_o && !$past(wake_flag_o)));

endmodule

// File: rtl/wkup_detect.sv
module wkup_detect
  import wkup_pkg::*;
#(
  parameter int T_WAKE = 16,
  parameter int T_BUS  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_pin_i,
  input  logic       bus_dom_i,
  input  logic [2:0] mode_i,
  input  logic       pwon_i,
  input  logic       uvnom_i,
  input  logic       uvnom_wait_i,
  output logic       wake_flag_o,
  output logic       wake_src_o,
  output logic       wake_evt_o
);
  logic rst_meta_q, rst_sync_q;
  logic local_hit, bus_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wkup_level_filter #(.T_STABLE(T_WAKE)) u_local (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .pin_i (wake_pin_i),
    .hit_o (local_hit)
  );

  wkup_dom_filter #(.T_DOM(T_BUS)) u_bus (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .dom_i (bus_dom_i),
    .hit_o (bus_hit)
  );

  wkup_flag_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .local_hit_i  (local_hit),
    .bus_hit_i    (bus_hit),
    .mode_i       (mode_i),
    .pwon_i       (pwon_i),
    .uvnom_i      (uvnom_i),
    .uvnom_wait_i (uvnom_wait_i),
    .wake_flag_o  (wake_flag_o),
    .wake_src_o   (wake_src_o),
    .wake_evt_o   (wake_evt_o)
  );

  // R1: outputs are quiet while reset is held.
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_q |=> (!wake_flag_o && !wake_src_o && !wake_evt_o));

endmodule

// File: tb/wkup_detect_bench.sv
module wkup_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;
  localparam int TB = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wake_pin, bus_dom, pwon, uvnom, uvwait;
  logic [2:0] mode;
  logic       wake_flag, wake_src, wake_evt;

  int checks = 0;
  int errors = 0;
  int evt_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wkup_detect #(.T_WAKE(TW), .T_BUS(TB)) u_wkup_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_pin_i   (wake_pin),
    .bus_dom_i    (bus_dom),
    .mode_i       (mode),
    .pwon_i       (pwon),
    .uvnom_i      (uvnom),
    .uvnom_wait_i (uvwait),
    .wake_flag_o  (wake_flag),
    .wake_src_o   (wake_src),
    .wake_evt_o   (wake_evt)
  );

  always @(negedge clk) if (rst_n && wake_evt) evt_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_to(input logic [2:0] m);
    mode = 3'd0;
    step(1);
    mode = m;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wake_pin = 1'b0; bus_dom = 1'b0; pwon = 1'b0;
    uvnom = 1'b0; uvwait = 1'b0; mode = 3'd2;
    step(3);
    chk("R1 flag in reset", wake_flag, 0);
    chk("R1 src in reset", wake_src, 0);
    chk("R1 evt in reset", wake_evt, 0);
    rst_n = 1'b1;
    step(4);
    chk("R1 flag after reset", wake_flag, 0);
    chk("R1 src after reset", wake_src, 0);

    // R2 R3: pulse length sweep for both polarities
    for (int b = 0; b < 2; b++) begin
      wake_pin = logic'(b);
      step(TW + 2);
      for (int len = 1; len <= TW + 2; len++) begin
        clear_to(3'd2);
        step(1);
        evt_cnt = 0;
        wake_pin = ~logic'(b);
        step(len);
        wake_pin = logic'(b);
        step(TW + 3);
        chk((len >= TW) ? "R2 local sweep flag" : "R3 short pulse flag", wake_flag, int'(len >= TW));
        chk("R10 sweep event count", evt_cnt, int'(len >= TW));
        chk("R8 sweep source", wake_src, int'(len >= TW));
      end
    end

    // R2: exact edge of the flag and pulse (stable level is 1 here)
    clear_to(3'd2);
    step(1);
    wake_pin = 1'b0;
    step(TW - 1);
    chk("R2 flag one edge early", wake_flag, 0);
    step(1);
    chk("R2 flag on time", wake_flag, 1);
    chk("R10 pulse on time", wake_evt, 1);
    step(1);
    chk("R10 pulse one cycle", wake_evt, 0);

    // R3: restart after interruption (stable level is 0)
    clear_to(3'd2);
    step(1);
    wake_pin = 1'b1;
    step(TW - 1);
    wake_pin = 1'b0;
    step(1);
    wake_pin = 1'b1;
    step(TW - 1);
    chk("R3 restarted count not reached", wake_flag, 0);
    step(1);
    chk("R3 restarted count reached", wake_flag, 1);

    // R4: bus dominance sweep
    for (int len = 1; len <= TB + 2; len++) begin
      clear_to(3'd3);
      step(1);
      bus_dom = 1'b1;
      step(len);
      bus_dom = 1'b0;
      step(3);
      chk("R4 bus sweep flag", wake_flag, int'(len >= TB));
      chk("R8 bus leaves source clear", wake_src, 0);
    end

    // R4: one request per dominant run
    clear_to(3'd4);
    step(1);
    bus_dom = 1'b1;
    step(TB + 1);
    chk("R4 long run sets flag", wake_flag, 1);
    clear_to(3'd4);
    step(2 * TB);
    chk("R4 same run no second request", wake_flag, 0);
    bus_dom = 1'b0;
    step(1);
    bus_dom = 1'b1;
    step(TB);
    chk("R4 new run sets flag", wake_flag, 1);
    bus_dom = 1'b0;

    // R5: mode sweep (stable level is 1)
    mode = 3'd1;
    step(1);
    for (int m = 0; m < 8; m++) begin
      mode = 3'd0;
      step(1);
      mode = 3'(m);
      step(1);
      wake_pin = ~wake_pin;
      step(TW + 2);
      chk("R5 mode sweep flag", wake_flag, int'(m >= 2 && m <= 4));
      chk("R5 mode sweep source", wake_src, int'(m >= 2 && m <= 4));
    end

    // R6: waiting period blocks requests
    clear_to(3'd2);
    uvwait = 1'b1;
    step(1);
    wake_pin = ~wake_pin;
    step(TW + 2);
    chk("R6 blocked during wait", wake_flag, 0);
    uvwait = 1'b0;
    wake_pin = ~wake_pin;
    step(TW + 2);
    chk("R6 accepted after wait", wake_flag, 1);

    // R7: undervoltage rise clears, and beats a request
    uvnom = 1'b1;
    step(1);
    chk("R7 undervoltage rise clears", wake_flag, 0);
    uvnom = 1'b0;
    step(1);
    wake_pin = ~wake_pin;
    step(TW - 1);
    uvnom = 1'b1;
    step(1);
    chk("R7 clear beats request", wake_flag, 0);
    wake_pin = ~wake_pin;
    step(TW + 1);
    chk("R7 held undervoltage does not block", wake_flag, 1);
    uvnom = 1'b0;
    mode = 3'd0;
    step(1);
    chk("R7 normal mode clears", wake_flag, 0);
    mode = 3'd2;
    step(1);

    // R8: power-on flag blocks source
    pwon = 1'b1;
    wake_pin = ~wake_pin;
    step(TW + 2);
    chk("R8 flag with pwon", wake_flag, 1);
    chk("R8 no source with pwon", wake_src, 0);
    pwon = 1'b0;

    // R9: source kept in normal, cleared on leaving
    clear_to(3'd2);
    step(1);
    wake_pin = ~wake_pin;
    step(TW + 2);
    chk("R9 source set", wake_src, 1);
    mode = 3'd0;
    step(5);
    chk("R9 source kept in normal", wake_src, 1);
    chk("R7 flag cleared in normal", wake_flag, 0);
    mode = 3'd2;
    step(1);
    chk("R9 source cleared on leaving", wake_src, 0);
    mode = 3'd0;
    step(1);
    wake_pin = ~wake_pin;
    step(TW - 1);
    mode = 3'd2;
    step(1);
    chk("R9 set wins over leave", wake_src, 1);
    chk("R9 flag set on leave edge", wake_flag, 1);

    // R10: no pulse while flag already set
    step(1);
    evt_cnt = 0;
    wake_pin = ~wake_pin;
    step(TW + 2);
    chk("R10 no pulse when set", evt_cnt, 0);
    chk("R10 flag still set", wake_flag, 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule